// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 512K bytes (19 address bits, 8 data bits). The host offers one word at a time on a request/ready handshake: an address, a write flag and write data go in when ready is high. For reads, the captured byte comes back with a one-cycle valid pulse. On the memory side the block drives active-low chip select, write enable and output enable, the address, and a split data bus (value, drive enable, and returned value) that an external tri-state pad joins into one bidirectional bus.

Every analog timing limit of the RAM is a parameter given in nanoseconds. The clock period is also a parameter. Each limit is turned into a whole number of cycles by rounding up, and never below one cycle. The read phase lasts long enough for both the address-to-data and the output-enable-to-data limits. The write-enable pulse is long enough for the minimum pulse width, the data setup before the rising edge and the full write cycle time. After a read, a bus-release wait keeps the controller's drivers off until the RAM has floated its pins.

A sleep input parks the RAM in standby with chip select high, as used for battery-backed retention. When sleep is cleared, a recovery wait of one read cycle time must pass before the host is offered ready again.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, chip select, write enable and output enable are all high, the data drive enable is low, read valid is low, and ready is high.
- R2: A read accepted at clock edge E drives chip select and output enable low, with write enable high and the request address on the memory address pins, from the cycle after E. The byte on the data input is captured on the last edge of that window. The read valid pulse is exactly one cycle long, in the cycle after the capture, and carries the captured byte.
- R3: The read window, in which chip select and output enable are low, lasts RD+2 cycles. RD is the larger of the address-access time and the output-enable-to-valid time, each divided by the clock period and rounded up (minimum one cycle). With the default parameters this is 5 cycles.
- R4: A write accepted at edge E holds chip select low for WP+2 cycles from the cycle after E, with output enable high throughout. Write enable is low for exactly WP cycles, starting in the second cycle of that window. WP is the largest of the rounded-up write-pulse width, the rounded-up data setup time, and the rounded-up write cycle time minus 2 (minimum one cycle). With the default parameters this is 3 cycles.
- R5: During a write, the data drive enable is high for the whole chip-select window, which includes one cycle after write enable rises. The driven value equals the request's write data and does not change while write enable is low.
- R6: After a read, chip select and output enable are high and the data drive enable stays low for REL cycles (the bus-release time rounded up) before ready returns. The controller never drives data while output enable is low.
- R7: Ready is high only when the sequencer is idle and awake. A write returns to ready in the cycle after its chip-select window ends. While ready is high, chip select is high.
- R8: While sleep is high, ready is low, and a request held high (including one raised in the same cycle as sleep) starts no memory cycle: chip select stays high.
- R9: After sleep is cleared, ready first reads high at the (REC+1)-th falling clock edge after the clearing. REC is the recovery time rounded up (3 cycles by default).
- R10: If sleep rises while a read is in progress, the read completes with the same timing and data as in R2 and R3, and only then does the block enter standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host request, taken when ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Sequencer can accept a request |
| host_rvalid | output | 1 | One-cycle read data valid pulse |
| host_rdata | output | 8 | Captured read byte |
| sleep | input | 1 | Request standby / retention |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_addr | output | 19 | RAM address |
| mem_dout | output | 8 | Data toward the pad |
| mem_dout_en | output | 1 | Pad drive enable |
| mem_din | input | 8 | Data from the pad |

## Verification
Two things can fall in the same cycle: entry into standby, and the start or continuation of a memory access. The bench raises sleep in the very cycle it raises a request, and judges the result by chip select staying high and ready staying low. It also raises sleep one cycle into a read, and judges that the read window length, the single valid pulse and the returned byte match an undisturbed read. In both cases the recovery delay after sleep is cleared is then counted against the rounded-up recovery time.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_SETUP,
        ST_READ_WAIT,
        ST_READ_CAPTURE,
        ST_WRITE_SETUP,
        ST_WRITE_PULSE,
        ST_WRITE_HOLD,
        ST_TURNAROUND
    } seq_state_t;

    typedef enum logic [1:0] {
        RET_AWAKE,
        RET_ASLEEP,
        RET_RECOVER
    } ret_state_t;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } pin_ctl_t;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Bits needed to hold the value v.
    function automatic int unsigned cnt_width(input int unsigned v);
        int unsigned w;
        w = 1;
        while ((64'd1 << w) <= 64'(v)) w++;
        return w;
    endfunction

    function automatic pin_ctl_t decode_pins(input seq_state_t s);
        pin_ctl_t p;
        p = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        case (s)
            ST_READ_SETUP, ST_READ_WAIT, ST_READ_CAPTURE: begin
                p.cs_n = 1'b0;
                p.oe_n = 1'b0;
            end
            ST_WRITE_SETUP, ST_WRITE_HOLD: begin
                p.cs_n  = 1'b0;
                p.drive = 1'b1;
            end
            ST_WRITE_PULSE: begin
                p.cs_n  = 1'b0;
                p.we_n  = 1'b0;
                p.drive = 1'b1;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt > CNT_W'(1)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Last cycle of a phase that was loaded with N: the N-th cycle after load.
    assign expire = (cnt <= CNT_W'(1));

endmodule

// File: rtl/asram_retention.sv
module asram_retention
    import asram_pkg::*;
#(
    parameter int unsigned REC_CYC = 3,
    parameter int unsigned CNT_W   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_i,
    input  logic fsm_idle_i,
    output logic awake_o
);
    ret_state_t st, st_nx;
    logic       tmr_load;
    logic       tmr_expire;

    assign tmr_load = (st == RET_ASLEEP) && !sleep_i;

    asram_phase_timer #(.CNT_W(CNT_W)) u_rec_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (CNT_W'(REC_CYC)),
        .expire   (tmr_expire)
    );

    always_comb begin
        st_nx = st;
        case (st)
            RET_AWAKE:   if (sleep_i && fsm_idle_i) st_nx = RET_ASLEEP;
            RET_ASLEEP:  if (!sleep_i) st_nx = RET_RECOVER;
            RET_RECOVER: begin
                if (sleep_i)         st_nx = RET_ASLEEP;
                else if (tmr_expire) st_nx = RET_AWAKE;
            end
            default:     st_nx = RET_AWAKE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= RET_AWAKE;
        else     st <= st_nx;
    end

    assign awake_o = (st == RET_AWAKE);

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
    parameter int unsigned ADDR_W = 19,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] pad_din,
    output logic [ADDR_W-1:0] pad_addr,
    output logic [DATA_W-1:0] pad_dout,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pad_addr <= '0;
            pad_dout <= '0;
        end else if (accept) begin
            pad_addr <= req_addr;
            pad_dout <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= pad_din;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W          = 19,
    parameter int unsigned DATA_W          = 8,
    parameter int unsigned CLK_PERIOD_NS   = 20,
    parameter int unsigned ACCESS_NS       = 55,
    parameter int unsigned OE_VALID_NS     = 30,
    parameter int unsigned WE_PULSE_NS     = 45,
    parameter int unsigned DATA_SETUP_NS   = 25,
    parameter int unsigned WRITE_CYCLE_NS  = 55,
    parameter int unsigned BUS_RELEASE_NS  = 30,
    parameter int unsigned RECOVERY_NS     = 55
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              sleep,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int unsigned RD_CYC  = max2(ns_to_cyc(ACCESS_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(OE_VALID_NS, CLK_PERIOD_NS));
    localparam int unsigned WC_CYC  = ns_to_cyc(WRITE_CYCLE_NS, CLK_PERIOD_NS);
    localparam int unsigned WC_REST = (WC_CYC > 2) ? WC_CYC - 2 : 1;
    localparam int unsigned WP_CYC  = max2(max2(ns_to_cyc(WE_PULSE_NS, CLK_PERIOD_NS),
                                                ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_NS)),
                                           WC_REST);
    localparam int unsigned REL_CYC = ns_to_cyc(BUS_RELEASE_NS, CLK_PERIOD_NS);
    localparam int unsigned REC_CYC = ns_to_cyc(RECOVERY_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WP_CYC), max2(REL_CYC, REC_CYC));
    localparam int unsigned CNT_W   = cnt_width(MAX_CYC);

    seq_state_t       state, state_nx;
    logic             awake;
    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;
    pin_ctl_t         pins;

    assign host_ready = (state == ST_IDLE) && awake && !sleep;
    assign accept     = host_req && host_ready;

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_IDLE: begin
                if (accept) state_nx = host_we ? ST_WRITE_SETUP : ST_READ_SETUP;
            end
            ST_READ_SETUP: begin
                state_nx = ST_READ_WAIT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RD_CYC);
            end
            ST_READ_WAIT: begin
                if (tmr_expire) state_nx = ST_READ_CAPTURE;
            end
            ST_READ_CAPTURE: begin
                state_nx = ST_TURNAROUND;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(REL_CYC);
            end
            ST_TURNAROUND: begin
                if (tmr_expire) state_nx = ST_IDLE;
            end
            ST_WRITE_SETUP: begin
                state_nx = ST_WRITE_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WP_CYC);
            end
            ST_WRITE_PULSE: begin
                if (tmr_expire) state_nx = ST_WRITE_HOLD;
            end
            ST_WRITE_HOLD: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    asram_phase_timer #(.CNT_W(CNT_W)) u_phase_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    asram_retention #(.REC_CYC(REC_CYC), .CNT_W(CNT_W)) u_retention (
        .clk        (clk),
        .rst        (rst),
        .sleep_i    (sleep),
        .fsm_idle_i (state == ST_IDLE),
        .awake_o    (awake)
    );

    asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (host_addr),
        .req_wdata (host_wdata),
        .capture   (state == ST_READ_CAPTURE),
        .pad_din   (mem_din),
        .pad_addr  (mem_addr),
        .pad_dout  (mem_dout),
        .rd_data   (host_rdata),
        .rd_valid  (host_rvalid)
    );

    assign pins        = decode_pins(state);
    assign mem_cs_n    = pins.cs_n;
    assign mem_we_n    = pins.we_n;
    assign mem_oe_n    = pins.oe_n;
    assign mem_dout_en = pins.drive;

endmodule

// File: rtl/asram_ctrl_checker.sv
module asram_ctrl_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dout_en,
    input logic [DATA_W-1:0] mem_dout
);
    a_r2_rvalid_single: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid);

    a_r4_we_inside_cs: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    a_r5_data_held_in_pulse: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_dout) && mem_dout_en));

    a_r5_drive_after_we_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> mem_dout_en);

    a_r6_no_drive_with_oe: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> mem_oe_n);

    a_r6_float_after_read: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |=> !mem_dout_en);

    a_r7_ready_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> (mem_cs_n && !mem_dout_en));

    a_r8_sleep_blocks_ready: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !host_ready);

endmodule

bind asram_ctrl asram_ctrl_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sleep       (sleep),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dout_en (mem_dout_en),
    .mem_dout    (mem_dout)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
    localparam int PER = 20;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RD  = (cyc(55) > cyc(30)) ? cyc(55) : cyc(30);
    localparam int WP  = (((cyc(45) > cyc(25)) ? cyc(45) : cyc(25)) > ((cyc(55) > 2) ? cyc(55) - 2 : 1))
                         ? ((cyc(45) > cyc(25)) ? cyc(45) : cyc(25)) : ((cyc(55) > 2) ? cyc(55) - 2 : 1);
    localparam int REL = cyc(30);
    localparam int REC = cyc(55);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [18:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [7:0]  host_rdata;
    logic        sleep = 1'b0;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din;
    logic [7:0]  ram [256];

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    asram_ctrl u_asram_ctrl (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata), .sleep(sleep),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din)
    );

    // Simple RAM model behind the pad.
    always @(posedge clk) begin
        if (!mem_cs_n && !mem_we_n) ram[mem_addr[7:0]] <= mem_dout;
    end
    assign mem_din = (!mem_cs_n && !mem_oe_n && mem_we_n) ? ram[mem_addr[7:0]] : 8'h00;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [18:0] addr_of(input int a);
        return 19'(a) | (19'(a) << 11);
    endfunction
    function automatic logic [7:0] data_of(input int a);
        return 8'(a * 37 + 5);
    endfunction

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        int cs_lo = 0, we_lo = 0, first_we = 0, drv = 0, bad = 0, rdy = 0;
        @(negedge clk);
        check(host_ready, "R7 ready before write", host_ready, 1);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0;
        for (int i = 1; i <= 40; i++) begin
            if (i > 1) @(negedge clk);
            if (!mem_cs_n) begin
                cs_lo++;
                if (mem_addr !== a) bad++;
            end
            if (!mem_we_n) begin
                we_lo++;
                if (first_we == 0) first_we = i;
            end
            if (!mem_oe_n) bad++;
            if (mem_dout_en) begin
                drv++;
                if (mem_dout !== d) bad++;
            end
            if (host_ready) begin rdy = i; break; end
        end
        check(cs_lo == WP + 2, "R4 cs window", cs_lo, WP + 2);
        check(we_lo == WP && first_we == 2, "R4 we pulse", we_lo * 10 + first_we, WP * 10 + 2);
        check(drv == WP + 2 && bad == 0, "R5 data drive", drv * 100 + bad, (WP + 2) * 100);
        check(rdy == WP + 3, "R7 ready after write", rdy, WP + 3);
    endtask

    task automatic do_read(input logic [18:0] a, input logic [7:0] d, input bit sleep_mid);
        int lo = 0, bad = 0, rv = 0, rv_idx = 0, rdy = 0, last;
        logic [7:0] got = '0;
        @(negedge clk);
        check(host_ready, "R7 ready before read", host_ready, 1);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_req = 1'b0;
        last = sleep_mid ? RD + REL + 8 : 40;
        for (int i = 1; i <= last; i++) begin
            if (i > 1) @(negedge clk);
            if (sleep_mid && i == 2) sleep = 1'b1;
            if (!mem_cs_n) begin
                lo++;
                if (mem_oe_n || !mem_we_n || mem_addr !== a) bad++;
            end
            if (mem_dout_en) bad++;
            if (host_rvalid) begin rv++; rv_idx = i; got = host_rdata; end
            if (host_ready) begin rdy = i; break; end
        end
        check(lo == RD + 2, sleep_mid ? "R10 read window" : "R3 read window", lo, RD + 2);
        check(bad == 0, "R2 read pins", bad, 0);
        check(rv == 1 && rv_idx == RD + 3, sleep_mid ? "R10 rvalid" : "R2 rvalid", rv * 100 + rv_idx, 100 + RD + 3);
        check(got == d, sleep_mid ? "R10 rdata" : "R2 rdata", got, d);
        if (sleep_mid) check(rdy == 0, "R8 ready held low", rdy, 0);
        else           check(rdy == RD + 3 + REL, "R6 turnaround", rdy, RD + 3 + REL);
    endtask

    task automatic wake_and_count();
        int k = 0;
        @(negedge clk);
        sleep = 1'b0;
        while (!host_ready && k < 30) begin
            @(negedge clk);
            k++;
        end
        check(k == REC + 1, "R9 recovery", k, REC + 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dout_en && !host_rvalid && host_ready,
              "R1 reset state", {mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en, host_rvalid, host_ready}, 6'b111001);

        // Sweep writes then reads over 64 addresses.
        for (int a = 0; a < 64; a++) do_write(addr_of(a), data_of(a));
        for (int a = 63; a >= 0; a--) do_read(addr_of(a), data_of(a), 1'b0);

        // Back-to-back read then write, write then read.
        do_read(addr_of(7), data_of(7), 1'b0);
        do_write(addr_of(7), 8'hA5);
        do_read(addr_of(7), 8'hA5, 1'b0);

        // R8: sleep and request raised in the same cycle.
        @(negedge clk);
        sleep = 1'b1; host_req = 1'b1; host_we = 1'b0; host_addr = addr_of(3);
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!mem_cs_n || host_ready) bad++;
        end
        check(bad == 0, "R8 request ignored in sleep", bad, 0);
        host_req = 1'b0;
        wake_and_count();
        do_read(addr_of(3), data_of(3), 1'b0);

        // R10: sleep rises one cycle into a read.
        do_read(addr_of(9), data_of(9), 1'b1);
        repeat (2) @(negedge clk);
        check(!host_ready && mem_cs_n, "R8 standby after read", host_ready, 0);
        wake_and_count();
        do_read(addr_of(9), data_of(9), 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule